// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous RAM with two fully independent ports, named left and right. Each port has an active-low chip select, an active-low output enable, an active-low write strobe, an address and write/read data. Either port can read or write any word in any cycle. Both ports may also work on the same word in the same cycle, and a fixed rule settles that case.

The two highest words of the address space also serve as mailboxes between the ports. The right port writes the left port's mailbox (depth-2), and that write raises the left port's active-low interrupt. The left port writes the right port's mailbox (depth-1), and that write raises the right port's interrupt. Each receiver clears its interrupt by touching its own mailbox with chip select and output enable low. The mailbox words stay ordinary storage throughout.

A parameter turns the interrupt function off. The two words are then plain memory and both interrupts stay high. With an address width of 14 the array is 16K x 16. The default width is smaller to keep elaboration light.

Top module: `dpram_mailbox`

## Requirements
- R1: A read cycle (cs_n=0, we_n=1, oe_n=0) on a port loads that port's read data output with the addressed word. The value is visible from the clock edge that samples the read.
- R2: Both ports work in the same cycle on different addresses without interfering. A word written by one port can be read back by the other port.
- R3: When a port does not perform a read cycle (oe_n=1, we_n=0 or cs_n=1), its read data output holds its previous value.
- R4: A port whose cs_n is high performs no access. A write strobe given with cs_n high leaves memory unchanged.
- R5: A right-port write (cs_n=0, we_n=0) to address depth-2 drives l_irq_n low from the next clock edge. A left-port write to depth-2 does not assert l_irq_n.
- R6: A left-port access of depth-2 with cs_n=0 and oe_n=0 deasserts l_irq_n, whatever we_n is. An access with oe_n=1 leaves l_irq_n low.
- R7: A left-port write to depth-1 drives r_irq_n low. A right-port access of depth-1 with cs_n=0 and oe_n=0 returns r_irq_n high.
- R8: The mailbox words store and return data like any other location.
- R9: If a flag is set and cleared in the same cycle, the set wins and the interrupt stays low.
- R10: If both ports write the same address in one cycle, the left data is stored. A read of an address that the other port writes in the same cycle returns the old contents.
- R11: Synchronous active-low reset drives both interrupt outputs high and both read data outputs to zero.
- R12: With MAILBOX_EN=0, both interrupt outputs stay high and the mailbox addresses behave as normal memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| l_cs_n | input | 1 | Left chip select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_irq_n | output | 1 | Left mailbox interrupt, active low |
| r_cs_n | input | 1 | Right chip select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_irq_n | output | 1 | Right mailbox interrupt, active low |

## Verification
Every result of this block sits one register away from its cause. Read data and both interrupt flags change at the same rising edge that samples the access. The bench applies each access at a falling edge and samples 1 ns after the following rising edge, where the new value must already stand. It then idles the ports before the next step, so that the hold and no-effect cases are observed in the same window.

// File: rtl/dpram_mailbox_pkg.sv
// Package: types and helpers shared by the mailbox dual-port RAM.
// Assumes: control pins are active low, as seen at the block ports.
package dpram_mailbox_pkg;

    // Decoded intent of one port for the current cycle.
    typedef struct packed {
        logic rd;   // read cycle: select, output enable, no write
        logic wr;   // write cycle: select and write strobe
        logic acc;  // mailbox touch: select and output enable
    } port_req_t;

    // Address of the word that belongs to the given side's mailbox.
    function automatic logic [31:0] mbx_index(input int unsigned depth, input logic right_side);
        return right_side ? 32'(depth - 1) : 32'(depth - 2);
    endfunction

endpackage

// File: rtl/dpram_port_decode.sv
// Module: turns one port's active-low controls into a decoded request.
// Assumes: inputs are sampled synchronously by the consumer; pure logic here.
module dpram_port_decode
    import dpram_mailbox_pkg::*;
(
    input  logic      cs_n,
    input  logic      oe_n,
    input  logic      we_n,
    output port_req_t req
);

    // Decode the three strobes; a deselected port requests nothing.
    always_comb begin
        req.rd  = !cs_n && we_n && !oe_n;
        req.wr  = !cs_n && !we_n;
        req.acc = !cs_n && !oe_n;
    end

endmodule

// File: rtl/dpram_core.sv
// Module: two-port storage array with registered read data per port.
// Assumes: same-address double write keeps the left data; reads return the
// contents from before any write in the same cycle. Array is not reset.
module dpram_core #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_wr,
    input  logic              r_rd,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store writes; the left write is applied last so it wins a collision.
    always_ff @(posedge clk) begin
        if (r_wr) begin
            mem[r_addr] <= r_wdata;
        end
        if (l_wr) begin
            mem[l_addr] <= l_wdata;
        end
    end

    // Left read register: cleared by reset, loaded only on a read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_rdata <= '0;
        end else if (l_rd) begin
            l_rdata <= mem[l_addr];
        end
    end

    // Right read register: cleared by reset, loaded only on a read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_rdata <= '0;
        end else if (r_rd) begin
            r_rdata <= mem[r_addr];
        end
    end

endmodule

// File: rtl/dpram_mailbox_flag.sv
// Module: one registered active-low interrupt flag with set priority.
// Assumes: set and clr are single-cycle qualified events from the decoders.
module dpram_mailbox_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag_n
);

    // Hold the flag; a set in the same cycle as a clear keeps it asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_n <= 1'b1;
        end else if (set) begin
            flag_n <= 1'b0;
        end else if (clr) begin
            flag_n <= 1'b1;
        end
    end

endmodule

// File: rtl/dpram_mailbox.sv
// Module: dual-port RAM whose two top words double as mailboxes that
// interrupt the opposite port when written.
// Assumes: one clock for both ports; synchronous active-low reset; the
// interrupt logic exists only when MAILBOX_EN is nonzero.
module dpram_mailbox
    import dpram_mailbox_pkg::*;
#(
    parameter int unsigned ADDR_W     = 11,
    parameter int unsigned DATA_W     = 16,
    parameter bit          MAILBOX_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs_n,
    input  logic              l_oe_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_cs_n,
    input  logic              r_oe_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);

    localparam int unsigned      DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] MBX_L = ADDR_W'(mbx_index(DEPTH, 1'b0));
    localparam logic [ADDR_W-1:0] MBX_R = ADDR_W'(mbx_index(DEPTH, 1'b1));

    port_req_t l_req;
    port_req_t r_req;

    dpram_port_decode u_dec_l (
        .cs_n (l_cs_n),
        .oe_n (l_oe_n),
        .we_n (l_we_n),
        .req  (l_req)
    );

    dpram_port_decode u_dec_r (
        .cs_n (r_cs_n),
        .oe_n (r_oe_n),
        .we_n (r_we_n),
        .req  (r_req)
    );

    dpram_core #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_wr    (l_req.wr),
        .l_rd    (l_req.rd),
        .l_addr  (l_addr),
        .l_wdata (l_wdata),
        .l_rdata (l_rdata),
        .r_wr    (r_req.wr),
        .r_rd    (r_req.rd),
        .r_addr  (r_addr),
        .r_wdata (r_wdata),
        .r_rdata (r_rdata)
    );

    generate
        if (MAILBOX_EN) begin : g_mbx
            logic set_l, clr_l, set_r, clr_r;

            // Mailbox events: the opposite side writes, the owner touches.
            always_comb begin
                set_l = r_req.wr  && (r_addr == MBX_L);
                clr_l = l_req.acc && (l_addr == MBX_L);
                set_r = l_req.wr  && (l_addr == MBX_R);
                clr_r = r_req.acc && (r_addr == MBX_R);
            end

            dpram_mailbox_flag u_flag_l (
                .clk    (clk),
                .rst_n  (rst_n),
                .set    (set_l),
                .clr    (clr_l),
                .flag_n (l_irq_n)
            );

            dpram_mailbox_flag u_flag_r (
                .clk    (clk),
                .rst_n  (rst_n),
                .set    (set_r),
                .clr    (clr_r),
                .flag_n (r_irq_n)
            );
        end else begin : g_no_mbx
            assign l_irq_n = 1'b1;
            assign r_irq_n = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/dpram_mailbox_chk.sv
// Module: property checker for dpram_mailbox, attached by bind below.
// Assumes: observes the top-level ports only.
module dpram_mailbox_chk #(
    parameter int unsigned ADDR_W     = 11,
    parameter int unsigned DATA_W     = 16,
    parameter bit          MAILBOX_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_cs_n,
    input logic              l_oe_n,
    input logic              l_we_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_irq_n,
    input logic              r_cs_n,
    input logic              r_oe_n,
    input logic              r_we_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_irq_n
);

    localparam int unsigned       DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] A_L   = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] A_R   = ADDR_W'(DEPTH - 1);

    logic ev_set_l, ev_clr_l, ev_set_r, ev_clr_r, l_read, r_read;

    // Recompute port-level events independently of the decoders.
    always_comb begin
        ev_set_l = (r_cs_n == 1'b0) && (r_we_n == 1'b0) && (r_addr == A_L);
        ev_clr_l = (l_cs_n == 1'b0) && (l_oe_n == 1'b0) && (l_addr == A_L);
        ev_set_r = (l_cs_n == 1'b0) && (l_we_n == 1'b0) && (l_addr == A_R);
        ev_clr_r = (r_cs_n == 1'b0) && (r_oe_n == 1'b0) && (r_addr == A_R);
        l_read   = (l_cs_n == 1'b0) && (l_oe_n == 1'b0) && (l_we_n == 1'b1);
        r_read   = (r_cs_n == 1'b0) && (r_oe_n == 1'b0) && (r_we_n == 1'b1);
    end

    assert_reset_irq_high_R11: assert property (@(posedge clk)
        !rst_n |=> (l_irq_n && r_irq_n));

    assert_reset_rdata_zero_R11: assert property (@(posedge clk)
        !rst_n |=> (l_rdata == '0 && r_rdata == '0));

    assert_l_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !l_read |=> $stable(l_rdata));

    assert_r_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !r_read |=> $stable(r_rdata));

    generate
        if (MAILBOX_EN) begin : g_on
            assert_l_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
                ev_set_l |=> !l_irq_n);

            assert_l_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(l_irq_n) |-> $past(ev_set_l));

            assert_l_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_clr_l && !ev_set_l) |=> l_irq_n);

            assert_l_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (!l_irq_n && !ev_clr_l) |=> !l_irq_n);

            assert_r_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ev_set_r |=> !r_irq_n);

            assert_r_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_clr_r && !ev_set_r) |=> r_irq_n);

            assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_set_l && ev_clr_l) |=> !l_irq_n);
        end else begin : g_off
            assert_quiet_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
                (l_irq_n && r_irq_n));
        end
    endgenerate

endmodule

bind dpram_mailbox dpram_mailbox_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .MAILBOX_EN (MAILBOX_EN)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_cs_n  (l_cs_n),
    .l_oe_n  (l_oe_n),
    .l_we_n  (l_we_n),
    .l_addr  (l_addr),
    .l_rdata (l_rdata),
    .l_irq_n (l_irq_n),
    .r_cs_n  (r_cs_n),
    .r_oe_n  (r_oe_n),
    .r_we_n  (r_we_n),
    .r_addr  (r_addr),
    .r_rdata (r_rdata),
    .r_irq_n (r_irq_n)
);

// File: tb/dpram_mailbox_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios for dpram_mailbox, one task per scenario.
module dpram_mailbox_tb_top;

    localparam int unsigned AW    = 11;
    localparam int unsigned DW    = 16;
    localparam int unsigned DEPTH = 1 << AW;
    localparam logic [AW-1:0] ML  = AW'(DEPTH - 2);
    localparam logic [AW-1:0] MR  = AW'(DEPTH - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_cs_n = 1'b1, l_oe_n = 1'b1, l_we_n = 1'b1;
    logic r_cs_n = 1'b1, r_oe_n = 1'b1, r_we_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata, o_l_rdata, o_r_rdata;
    logic l_irq_n, r_irq_n, o_l_irq_n, o_r_irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW), .MAILBOX_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW), .MAILBOX_EN(1'b0)) dut_off_i (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(o_l_rdata), .l_irq_n(o_l_irq_n),
        .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(o_r_rdata), .r_irq_n(o_r_irq_n)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one cycle of port controls at a falling edge; sample after the rise.
    task automatic cyc(input logic lc, input logic lo, input logic lw,
                       input logic [AW-1:0] la, input logic [DW-1:0] ld,
                       input logic rc, input logic ro, input logic rw,
                       input logic [AW-1:0] ra, input logic [DW-1:0] rd);
        @(negedge clk);
        l_cs_n = lc; l_oe_n = lo; l_we_n = lw; l_addr = la; l_wdata = ld;
        r_cs_n = rc; r_oe_n = ro; r_we_n = rw; r_addr = ra; r_wdata = rd;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(1, 1, 1, '0, '0, 1, 1, 1, '0, '0);
    endtask

    task automatic t_reset();
        check("R11", "l_rdata after reset", 32'(l_rdata), 32'h0);
        check("R11", "r_rdata after reset", 32'(r_rdata), 32'h0);
        check("R11", "l_irq_n after reset", 32'(l_irq_n), 32'h1);
        check("R11", "r_irq_n after reset", 32'(r_irq_n), 32'h1);
    endtask

    task automatic t_basic();
        cyc(0, 1, 0, 11'd5, 16'h1234, 0, 1, 0, 11'd9, 16'hABCD);
        cyc(0, 0, 1, 11'd9, '0, 0, 0, 1, 11'd5, '0);
        check("R1", "left read of right-written word", 32'(l_rdata), 32'hABCD);
        check("R2", "right read of left-written word", 32'(r_rdata), 32'h1234);
        idle();
        check("R3", "l_rdata held while idle", 32'(l_rdata), 32'hABCD);
    endtask

    task automatic t_no_access();
        cyc(0, 1, 1, 11'd5, '0, 1, 1, 1, '0, '0);
        check("R3", "read with oe_n high holds data", 32'(l_rdata), 32'hABCD);
        cyc(1, 0, 0, 11'd5, 16'hFFFF, 1, 1, 1, '0, '0);
        check("R4", "deselected port read data unchanged", 32'(l_rdata), 32'hABCD);
        cyc(0, 0, 1, 11'd5, '0, 1, 1, 1, '0, '0);
        check("R4", "write with cs_n high ignored", 32'(l_rdata), 32'h1234);
    endtask

    task automatic t_left_mailbox();
        cyc(1, 1, 1, '0, '0, 0, 1, 0, ML, 16'h5A5A);
        check("R5", "l_irq_n after right write to depth-2", 32'(l_irq_n), 32'h0);
        check("R5", "r_irq_n untouched", 32'(r_irq_n), 32'h1);
        check("R12", "disabled instance l_irq_n", 32'(o_l_irq_n), 32'h1);
        cyc(0, 1, 1, ML, '0, 1, 1, 1, '0, '0);
        check("R6", "l_irq_n stays low with oe_n high", 32'(l_irq_n), 32'h0);
        cyc(0, 0, 0, ML, 16'h1111, 1, 1, 1, '0, '0);
        check("R6", "l_irq_n cleared by write access with oe_n low", 32'(l_irq_n), 32'h1);
        cyc(1, 1, 1, '0, '0, 0, 1, 0, ML, 16'h5A5A);
        cyc(0, 0, 1, ML, '0, 1, 1, 1, '0, '0);
        check("R6", "l_irq_n cleared by read", 32'(l_irq_n), 32'h1);
        check("R8", "left mailbox word content", 32'(l_rdata), 32'h5A5A);
        cyc(0, 1, 0, ML, 16'h7777, 1, 1, 1, '0, '0);
        check("R5", "own write to depth-2 sets nothing", 32'(l_irq_n), 32'h1);
        cyc(1, 1, 1, '0, '0, 0, 0, 1, ML, '0);
        check("R8", "depth-2 readable by right", 32'(r_rdata), 32'h7777);
    endtask

    task automatic t_right_mailbox();
        cyc(0, 1, 0, MR, 16'hC3C3, 1, 1, 1, '0, '0);
        check("R7", "r_irq_n after left write to depth-1", 32'(r_irq_n), 32'h0);
        check("R12", "disabled instance r_irq_n", 32'(o_r_irq_n), 32'h1);
        cyc(1, 1, 1, '0, '0, 0, 0, 1, MR, '0);
        check("R7", "r_irq_n cleared by right read", 32'(r_irq_n), 32'h1);
        check("R8", "right mailbox word content", 32'(r_rdata), 32'hC3C3);
    endtask

    task automatic t_set_wins();
        cyc(0, 1, 0, MR, 16'h0F0F, 0, 0, 1, MR, '0);
        check("R9", "set beats clear in same cycle", 32'(r_irq_n), 32'h0);
        check("R10", "read during other-port write returns old", 32'(r_rdata), 32'hC3C3);
        cyc(1, 1, 1, '0, '0, 0, 0, 1, MR, '0);
        check("R9", "later clear works", 32'(r_irq_n), 32'h1);
        check("R8", "new mailbox data", 32'(r_rdata), 32'h0F0F);
    endtask

    task automatic t_collision();
        cyc(0, 1, 0, 11'd20, 16'h1111, 0, 1, 0, 11'd20, 16'h2222);
        cyc(0, 0, 1, 11'd20, '0, 0, 0, 1, 11'd20, '0);
        check("R10", "collision left read", 32'(l_rdata), 32'h1111);
        check("R10", "collision right read", 32'(r_rdata), 32'h1111);
    endtask

    task automatic t_disabled_memory();
        cyc(1, 1, 1, '0, '0, 0, 1, 0, ML, 16'h4242);
        check("R12", "disabled l_irq_n after mailbox write", 32'(o_l_irq_n), 32'h1);
        cyc(0, 0, 1, ML, '0, 1, 1, 1, '0, '0);
        check("R12", "disabled depth-2 is plain memory", 32'(o_l_rdata), 32'h4242);
        idle();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0;
        @(posedge clk);
        #1;
        t_reset();
        t_basic();
        t_no_access();
        t_left_mailbox();
        t_right_mailbox();
        t_set_wins();
        t_collision();
        t_disabled_memory();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule